// File: doc/BRIEF.md
# Triggered Multi-Frame Sample Capture

This block sits at the end of a receive chain. The chain delivers complex samples that are already grouped into frames, with a start marker and an end marker on each frame and a valid qualifier on each sample. Software sets a frame count and selects a data source, then writes a trigger. From that point the block waits for the next start-of-frame. It then collects exactly the programmed number of whole frames, packs four samples into each 128-bit word, and sends the words out as an AXI4-Stream. The final word carries TLAST.

A test source can stand in for the live samples. In that mode the real half of each captured sample is its position inside the frame, and the imaginary half is the number of the frame since the trigger. Software can then check the captured data for gaps, repeats and wrong counter wraps. When the test source is off, the live samples are forwarded unchanged, and no register stage is added in front of the packer.

When the downstream sink stalls, the output word is held. The block then lowers its own input ready, but only when a freshly completed word has nowhere to go. No accepted sample is lost.

Top module: `frame_burst_capture`

## Requirements
- R1: After reset, m_tvalid, busy and done are low, and in_ready is high.
- R2: A write to register address 2 while no capture is running arms the block, and busy rises on the next cycle. Only a sample that has in_sof high and is accepted after the trigger cycle starts a capture. Samples accepted before it are dropped.
- R3: A capture delivers exactly N × 512 samples as N × 128 output beats, and no beat follows the last one. N is cfg_wdata[10:0] written at address 0, and a written 0 counts as 1.
- R4: Within a beat, the k-th captured sample of that beat (k = 0..3) occupies bits [32k+31:32k]. Its imaginary part is in the upper 16 bits of that lane and its real part in the lower 16 bits, so the earliest sample is in the least significant lane.
- R5: m_tlast is high on the final beat of a capture and on no other beat.
- R6: With bit 0 of address 1 set, the real part is the sample index within the frame (0..511) and the imaginary part is the frame index since the trigger, both zero-extended and both restarted by the trigger. The mode and N are sampled when the trigger is written, and later writes do not affect a running capture.
- R7: With bit 0 of address 1 clear, each captured sample equals the input sample accepted at that position.
- R8: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata and m_tlast hold their values. No accepted sample is lost or repeated across a stall.
- R9: A trigger written while a capture is in progress has no effect on the data, the beat count or the end of that capture.
- R10: done goes high once the final beat has been accepted and stays high until the next trigger. busy and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 frame count, 1 mode, 2 trigger |
| cfg_wdata | input | 32 | Register write data |
| in_re | input | 16 | Input sample, real part, signed Q1.15 |
| in_im | input | 16 | Input sample, imaginary part, signed Q1.15 |
| in_sof | input | 1 | First sample of a frame |
| in_eof | input | 1 | Last sample of a frame |
| in_valid | input | 1 | Input sample qualifier |
| in_ready | output | 1 | Block accepts the input sample this cycle |
| m_tdata | output | 128 | Four packed complex samples |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts the beat |
| m_tlast | output | 1 | Final beat of the capture |
| busy | output | 1 | Armed or capturing |
| done | output | 1 | Capture complete and fully drained |

## Verification
A lane, sample or frame counter that slips by one shows up at once in the data of the next accepted beat. In test-pattern mode the error appears as a broken index sequence. In forward mode it appears as a sample that does not match its source position. A wrong end condition shows up at the end of the capture: TLAST arrives on the wrong beat, or an extra beat appears, within one beat of the expected end. A state machine that arms on the wrong marker shifts the first captured frame, and this is visible in the first beat. Stall handling is checked cycle by cycle: any change of the held word during backpressure is seen on the cycle it happens, and a dropped sample corrupts the next beat.

// File: rtl/frame_burst_capture.sv
module frame_burst_capture #(
  parameter int SAMP_W     = 16,
  parameter int FRAME_LEN  = 512,
  parameter int MAX_FRAMES = 1024,
  parameter int LANES      = 4,
  parameter int CFG_AW     = 2,
  parameter int CFG_DW     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [CFG_AW-1:0]           cfg_addr,
  input  logic [CFG_DW-1:0]           cfg_wdata,
  input  logic [SAMP_W-1:0]           in_re,
  input  logic [SAMP_W-1:0]           in_im,
  input  logic                        in_sof,
  input  logic                        in_eof,
  input  logic                        in_valid,
  output logic                        in_ready,
  output logic [LANES*2*SAMP_W-1:0]   m_tdata,
  output logic                        m_tvalid,
  input  logic                        m_tready,
  output logic                        m_tlast,
  output logic                        busy,
  output logic                        done
);
  localparam int LW     = 2 * SAMP_W;
  localparam int BEAT_W = LANES * LW;
  localparam int NF_W   = $clog2(MAX_FRAMES + 1);
  localparam int SI_W   = $clog2(FRAME_LEN);
  localparam int LN_W   = $clog2(LANES);
  localparam logic [CFG_AW-1:0] A_COUNT = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] A_MODE  = CFG_AW'(1);
  localparam logic [CFG_AW-1:0] A_TRIG  = CFG_AW'(2);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_CAP, S_DONE} st_t;

  st_t               st;
  logic [NF_W-1:0]   nframes, nf_cap;
  logic              mode_reg, pat_cap;
  logic [SI_W-1:0]   samp_idx;
  logic [NF_W-1:0]   frame_idx;
  logic [LN_W-1:0]   lane_q;
  logic [BEAT_W-LW-1:0] pack;
  logic [BEAT_W-1:0] out_data;
  logic              out_valid, out_last;

  wire unused_bits = ^{in_eof, cfg_wdata[CFG_DW-1:NF_W]};

  wire trig      = cfg_we && (cfg_addr == A_TRIG);
  wire rearm     = trig && (st != S_CAP);
  wire top_lane  = (lane_q == LN_W'(LANES - 1));
  wire stall     = top_lane && out_valid && !m_tready;
  assign in_ready = (st == S_CAP) ? !stall : 1'b1;

  wire take      = in_valid && in_ready;
  wire start     = (st == S_ARMED) && !trig && take && in_sof;
  wire cap_take  = take && ((st == S_CAP) || start);
  wire frame_end = (samp_idx == SI_W'(FRAME_LEN - 1));
  wire last_smp  = frame_end && (frame_idx == nf_cap - NF_W'(1));
  wire beat_full = cap_take && top_lane;

  wire [SAMP_W-1:0] smp_re = pat_cap ? SAMP_W'(samp_idx)  : in_re;
  wire [SAMP_W-1:0] smp_im = pat_cap ? SAMP_W'(frame_idx) : in_im;
  wire [LW-1:0]     smp    = {smp_im, smp_re};

  wire [NF_W-1:0] nf_wr = (cfg_wdata[NF_W-1:0] == '0) ? NF_W'(1) : cfg_wdata[NF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nframes  <= NF_W'(1);
      mode_reg <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr == A_COUNT) nframes  <= nf_wr;
      if (cfg_addr == A_MODE)  mode_reg <= cfg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE:  if (trig) st <= S_ARMED;
        S_ARMED: if (start) st <= S_CAP;
        S_CAP:   if (cap_take && last_smp) st <= S_DONE;
        S_DONE:  if (trig) st <= S_ARMED;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_idx  <= '0;
      frame_idx <= '0;
      lane_q    <= '0;
      nf_cap    <= NF_W'(1);
      pat_cap   <= 1'b0;
    end else if (rearm) begin
      samp_idx  <= '0;
      frame_idx <= '0;
      lane_q    <= '0;
      nf_cap    <= nframes;
      pat_cap   <= mode_reg;
    end else if (cap_take) begin
      lane_q <= LN_W'(lane_q + 1'b1);
      if (frame_end) begin
        samp_idx  <= '0;
        frame_idx <= NF_W'(frame_idx + 1'b1);
      end else begin
        samp_idx  <= SI_W'(samp_idx + 1'b1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pack <= '0;
    else if (cap_take && !top_lane) pack[lane_q*LW +: LW] <= smp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else if (beat_full) begin
      out_valid <= 1'b1;
      out_last  <= last_smp;
      out_data  <= {smp, pack};
    end else if (m_tready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end

  assign m_tdata  = out_data;
  assign m_tvalid = out_valid;
  assign m_tlast  = out_last;
  assign busy     = (st == S_ARMED) || (st == S_CAP);
  assign done     = (st == S_DONE) && !out_valid;
endmodule

module frame_burst_capture_chk #(
  parameter int BEAT_W = 128,
  parameter int CFG_AW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic              in_ready,
  input logic [BEAT_W-1:0] m_tdata,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic              m_tlast,
  input logic              busy,
  input logic              done
);
  wire trig_wr = cfg_we && (cfg_addr == CFG_AW'(2));

  p_trig_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr && !busy |=> busy);

  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> in_ready);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && m_tlast |=> !m_tvalid);

  p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && m_tlast && !trig_wr |=> !busy);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind frame_burst_capture frame_burst_capture_chk #(
  .BEAT_W(LANES*2*SAMP_W), .CFG_AW(CFG_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .in_ready(in_ready), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
  .m_tready(m_tready), .m_tlast(m_tlast), .busy(busy), .done(done)
);

// File: tb/tb_frame_burst_capture.sv
module tb_frame_burst_capture;
  localparam int FL = 512;
  localparam int NROWS = 6;
  // row: {exp_beats[11:0], mid_trig, vpat[1:0], rpat[1:0], mode, nf[10:0]}
  localparam logic [28:0] VEC [NROWS] = '{
    {12'd128, 1'b0, 2'd0, 2'd0, 1'b1, 11'd1},
    {12'd256, 1'b0, 2'd0, 2'd1, 1'b0, 11'd2},
    {12'd128, 1'b0, 2'd1, 2'd0, 1'b0, 11'd0},
    {12'd384, 1'b1, 2'd1, 2'd2, 1'b1, 11'd3},
    {12'd256, 1'b0, 2'd0, 2'd3, 1'b1, 11'd2},
    {12'd128, 1'b1, 2'd1, 2'd3, 1'b0, 11'd1}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_we, in_sof, in_eof, in_valid, in_ready;
  logic [1:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic [15:0] in_re, in_im;
  logic [127:0] m_tdata;
  logic m_tvalid, m_tready, m_tlast, busy, done;

  frame_burst_capture dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_re(in_re), .in_im(in_im), .in_sof(in_sof), .in_eof(in_eof), .in_valid(in_valid),
    .in_ready(in_ready), .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tlast(m_tlast), .busy(busy), .done(done)
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  bit run = 0;
  int cyc = 0, src_pos = 0, src_frame = 0;
  bit armed, started, last_seen, cur_mode, prev_stall, prev_last;
  int f0, beat_n, exp_beats, post_valid;
  int rpat, vpat;
  logic [127:0] prev_data;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_word(input int b, input bit md, input int f0v);
    logic [127:0] w;
    for (int j = 0; j < 4; j++) begin
      int k;
      logic [15:0] re, im;
      k = 4 * b + j;
      if (md) begin
        re = 16'(k % FL);
        im = 16'(k / FL);
      end else begin
        re = 16'(k % FL) ^ 16'hA500;
        im = 16'(f0v + k / FL) ^ 16'h3C00;
      end
      w[32*j +: 32] = {im, re};
    end
    return w;
  endfunction

  always @(negedge clk) begin
    if (run) begin
      cyc++;
      case (rpat)
        0: m_tready = 1'b1;
        1: m_tready = (cyc % 2) == 0;
        2: m_tready = (cyc % 7) != 3;
        default: m_tready = (cyc % 16) < 6;
      endcase
      in_valid = (vpat == 0) ? 1'b1 : ((cyc % 5) != 2);
      in_re  = 16'(src_pos) ^ 16'hA500;
      in_im  = 16'(src_frame) ^ 16'h3C00;
      in_sof = (src_pos == 0);
      in_eof = (src_pos == FL - 1);
      #1;
      if (prev_stall)
        chk(m_tvalid && m_tdata == prev_data && m_tlast == prev_last, "R8 hold",
            {m_tvalid, m_tlast, m_tdata[125:0]}, {1'b1, prev_last, prev_data[125:0]});
      prev_stall = m_tvalid && !m_tready;
      prev_data  = m_tdata;
      prev_last  = m_tlast;
      if (in_valid && in_ready) begin
        if (armed && !started && in_sof) begin
          started = 1;
          f0 = src_frame;
        end
        if (src_pos == FL - 1) begin
          src_pos = 0;
          src_frame++;
        end else src_pos++;
      end
      if (cfg_we && cfg_addr == 2'd2 && !started) armed = 1;
      if (last_seen && m_tvalid) post_valid++;
      if (m_tvalid && m_tready) begin
        chk(m_tdata == exp_word(beat_n, cur_mode, f0), cur_mode ? "R4 R6 pattern" : "R4 R7 forward",
            m_tdata, exp_word(beat_n, cur_mode, f0));
        chk(m_tlast == (beat_n == exp_beats - 1), "R5 last", 128'(m_tlast), 128'(beat_n == exp_beats - 1));
        if (m_tlast) last_seen = 1;
        beat_n++;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog actual=timeout expected=capture end");
    summary();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_re = '0; in_im = '0; in_sof = 1'b0; in_eof = 1'b0; m_tready = 1'b1;
    rpat = 0; vpat = 0;
    repeat (5) @(posedge clk);
    @(negedge clk); #1;
    chk(!m_tvalid && !busy && !done && in_ready, "R1 reset",
        {m_tvalid, busy, done, in_ready}, 4'b0001);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      wr(2'd0, {21'd0, VEC[i][10:0]});
      wr(2'd1, {31'd0, VEC[i][11]});
      @(negedge clk);
      armed = 0; started = 0; last_seen = 0; beat_n = 0; post_valid = 0; prev_stall = 0;
      cur_mode = VEC[i][11];
      rpat = int'(VEC[i][13:12]);
      vpat = int'(VEC[i][15:14]);
      exp_beats = int'(VEC[i][28:17]);
      run = 1;
      repeat (37 + 101 * i) @(negedge clk);
      wr(2'd2, 32'd1);
      #1;
      if (!started)
        chk(busy && !done, "R2 busy after trigger", {busy, done}, 2'b10);
      if (VEC[i][16]) begin
        while (beat_n < 40) @(negedge clk);
        wr(2'd1, {31'd0, ~VEC[i][11]});
        wr(2'd2, 32'd1);
        #1;
        chk(busy, "R9 trigger in capture keeps busy", 128'(busy), 128'd1);
      end
      while (!last_seen) @(negedge clk);
      repeat (20) @(negedge clk);
      #2;
      chk(beat_n == exp_beats, "R3 beat count", 128'(beat_n), 128'(exp_beats));
      chk(post_valid == 0, "R3 no overflow beat", 128'(post_valid), 128'd0);
      chk(done && !busy, "R10 done", {done, busy}, 2'b10);
    end
    summary();
  end
endmodule